// File: doc/BRIEF.md
# Security-Banked Binary Point Register

This block is the per-CPU binary point slice of an interrupt controller's CPU interface. For each CPU it holds a primary binary point value, an aliased (non-secure) binary point value, and a control bit that says whether the non-secure world shares the primary value. All of this storage is reached through one register offset on a simple register bus. That bus carries a request strobe, a write enable, an address, write data, a secure attribute and a CPU index.

The route an access takes depends on three things: the security-extension flag, the access's secure attribute and the selected CPU's share bit. Secure accesses, and every access when the extension is absent, use the primary value. A non-secure access with sharing off uses the aliased copy. A non-secure access with sharing on reads the primary value plus one, saturated at 7, and its writes are dropped without any error. The share bits are loaded through a dedicated control write port.

Top module: `sec_binpt_bank`

## Requirements
- R1: After reset every CPU's primary value is 2, every aliased value is 3, every share bit is 0, and `rdata_o` is 0.
- R2: Only accesses with `addr_i` equal to 0x008 reach the slice. A read at any other address returns 0, and a write at any other address changes no stored value.
- R3: A secure access, or any access while `sec_ext_i` is 0, reads the primary value. A write of this kind stores `wdata_i[2:0]`, raised to 2 if it is below 2.
- R4: A non-secure access with `sec_ext_i` 1 and share bit 0 reads the aliased value. A write of this kind stores `wdata_i[2:0]`, raised to 3 if it is below 3.
- R5: A non-secure read with `sec_ext_i` 1 and share bit 1 returns the primary value plus one, capped at 7, so a primary value of 7 reads as 7.
- R6: A non-secure write with `sec_ext_i` 1 and share bit 1 changes neither the primary value nor the aliased value.
- R7: `cpu_sel_i` selects which CPU's values and share bit an access uses. The other CPUs are untouched.
- R8: When `ctl_we_i` is high, the share bit of CPU `ctl_cpu_i` takes `ctl_share_i` at the next clock edge. A bus access in the same cycle still sees the old bit.
- R9: Read data appears on `rdata_o` in the cycle after the read strobe, zero-extended to 32 bits. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Register offset |
| wdata_i | input | 32 | Write data |
| secure_i | input | 1 | Access is secure |
| sec_ext_i | input | 1 | Security extension present |
| cpu_sel_i | input | 2 | CPU index for the bus access |
| ctl_we_i | input | 1 | Share bit write enable |
| ctl_cpu_i | input | 2 | CPU index for the share bit write |
| ctl_share_i | input | 1 | New share bit value |
| rdata_o | output | 32 | Registered read data |

## Verification
The bench drives secure, extension-absent and both kinds of non-secure accesses against the same stored values. A secure read taken after a non-secure write shows which copy the write reached. Write data below each minimum, data with high bits set, and a primary value of 7 under sharing separate the clamp, the mask and the saturation paths. Two CPUs with different share bits, control writes that coincide with bus accesses, and off-offset traffic show whether selection, update timing and address decode are right. A long pseudo-random phase is compared on every clock against a behavioural model.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  localparam int PT_W = 3;

  typedef enum logic [1:0] {
    ROUTE_NONE,
    ROUTE_PRI,
    ROUTE_ALIAS,
    ROUTE_SHARED
  } route_e;

  function automatic logic [PT_W-1:0] clamp_pt(input logic [31:0] d, input logic [PT_W-1:0] lo);
    return (d[PT_W-1:0] < lo) ? lo : d[PT_W-1:0];
  endfunction
endpackage

// File: rtl/sbp_route.sv
module sbp_route
  import sbp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFFSET = 'h8
) (
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              secure_i,
  input  logic              sec_ext_i,
  input  logic              share_i,
  output route_e            route_o
);
  always_comb begin
    if (!req_i || addr_i != OFFSET)   route_o = ROUTE_NONE;
    else if (!sec_ext_i || secure_i)  route_o = ROUTE_PRI;
    else if (share_i)                 route_o = ROUTE_SHARED;
    else                              route_o = ROUTE_ALIAS;
  end
endmodule

// File: rtl/sbp_store.sv
module sbp_store
  import sbp_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = 2,
  parameter int MIN_PRI = 2,
  parameter int MIN_ALI = 3
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_pri_i,
  input  logic                           wr_ali_i,
  input  logic [CPU_W-1:0]               wr_cpu_i,
  input  logic [31:0]                    wdata_i,
  input  logic                           ctl_we_i,
  input  logic [CPU_W-1:0]               ctl_cpu_i,
  input  logic                           ctl_val_i,
  output logic [NUM_CPU-1:0][PT_W-1:0]   pri_o,
  output logic [NUM_CPU-1:0][PT_W-1:0]   ali_o,
  output logic [NUM_CPU-1:0]             share_o
);
  localparam logic [PT_W-1:0] PRI_LO = PT_W'(MIN_PRI);
  localparam logic [PT_W-1:0] ALI_LO = PT_W'(MIN_ALI);

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
    logic sel_bus, sel_ctl;
    assign sel_bus = (wr_cpu_i == CPU_W'(g));
    assign sel_ctl = ctl_we_i && (ctl_cpu_i == CPU_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pri_o[g]   <= PRI_LO;
        ali_o[g]   <= ALI_LO;
        share_o[g] <= 1'b0;
      end else begin
        if (wr_pri_i && sel_bus) pri_o[g] <= clamp_pt(wdata_i, PRI_LO);
        if (wr_ali_i && sel_bus) ali_o[g] <= clamp_pt(wdata_i, ALI_LO);
        if (sel_ctl)             share_o[g] <= ctl_val_i;
      end
    end
  end
endmodule

// File: rtl/sbp_view.sv
module sbp_view
  import sbp_pkg::*;
(
  input  route_e          route_i,
  input  logic [PT_W-1:0] pri_i,
  input  logic [PT_W-1:0] ali_i,
  output logic [PT_W-1:0] val_o
);
  always_comb begin
    unique case (route_i)
      ROUTE_PRI:    val_o = pri_i;
      ROUTE_ALIAS:  val_o = ali_i;
      ROUTE_SHARED: val_o = (&pri_i) ? pri_i : pri_i + 1'b1;  // saturate at max
      default:      val_o = '0;
    endcase
  end
endmodule

// File: rtl/sec_binpt_bank.sv
module sec_binpt_bank
  import sbp_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int MIN_PRI = 2,
  parameter int MIN_ALI = 3,
  parameter logic [ADDR_W-1:0] OFFSET = 'h8,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              secure_i,
  input  logic              sec_ext_i,
  input  logic [CPU_W-1:0]  cpu_sel_i,
  input  logic              ctl_we_i,
  input  logic [CPU_W-1:0]  ctl_cpu_i,
  input  logic              ctl_share_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [NUM_CPU-1:0][PT_W-1:0] pri_all, ali_all;
  logic [NUM_CPU-1:0]           share_all;
  route_e                       route;
  logic [PT_W-1:0]              view;
  logic [31:0]                  wd32;

  assign wd32 = 32'(wdata_i);

  sbp_route #(.ADDR_W(ADDR_W), .OFFSET(OFFSET)) u_route (
    .req_i     (req_i),
    .addr_i    (addr_i),
    .secure_i  (secure_i),
    .sec_ext_i (sec_ext_i),
    .share_i   (share_all[cpu_sel_i]),
    .route_o   (route)
  );

  sbp_store #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .MIN_PRI(MIN_PRI), .MIN_ALI(MIN_ALI)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_pri_i  (we_i && route == ROUTE_PRI),
    .wr_ali_i  (we_i && route == ROUTE_ALIAS),
    .wr_cpu_i  (cpu_sel_i),
    .wdata_i   (wd32),
    .ctl_we_i  (ctl_we_i),
    .ctl_cpu_i (ctl_cpu_i),
    .ctl_val_i (ctl_share_i),
    .pri_o     (pri_all),
    .ali_o     (ali_all),
    .share_o   (share_all)
  );

  sbp_view u_view (
    .route_i (route),
    .pri_i   (pri_all[cpu_sel_i]),
    .ali_i   (ali_all[cpu_sel_i]),
    .val_o   (view)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rdata_o <= '0;
    else if (req_i && !we_i) rdata_o <= DATA_W'(view);
  end
endmodule

// File: rtl/sbp_chk.sv
module sbp_chk
  import sbp_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int MIN_PRI = 2,
  parameter int MIN_ALI = 3,
  parameter logic [ADDR_W-1:0] OFFSET = 'h8,
  parameter int CPU_W = 2
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         req_i,
  input logic                         we_i,
  input logic [ADDR_W-1:0]            addr_i,
  input logic                         secure_i,
  input logic                         sec_ext_i,
  input logic [CPU_W-1:0]             cpu_sel_i,
  input logic                         ctl_we_i,
  input logic [CPU_W-1:0]             ctl_cpu_i,
  input logic                         ctl_share_i,
  input logic [DATA_W-1:0]            rdata_o,
  input logic [NUM_CPU-1:0][PT_W-1:0] pri_all,
  input logic [NUM_CPU-1:0][PT_W-1:0] ali_all,
  input logic [NUM_CPU-1:0]           share_all
);
  logic [CPU_W-1:0] ctl_cpu_q;
  logic             shared_ns;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ctl_cpu_q <= '0;
    else         ctl_cpu_q <= ctl_cpu_i;

  assign shared_ns = req_i && addr_i == OFFSET && sec_ext_i && !secure_i && share_all[cpu_sel_i];

  // R9
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:PT_W] == '0);
  // R9
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
  // R2
  miss_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && addr_i != OFFSET |=> $stable(pri_all) && $stable(ali_all));
  // R2
  miss_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && addr_i != OFFSET |=> rdata_o == '0);
  // R6
  drop_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shared_ns && we_i |=> $stable(pri_all) && $stable(ali_all));
  // R5
  shared_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shared_ns && !we_i |=> rdata_o >= DATA_W'(MIN_PRI + 1));
  // R8
  ctl_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> share_all[ctl_cpu_q] == $past(ctl_share_i));

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_floor
    // R3
    pri_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pri_all[g] >= PT_W'(MIN_PRI));
    // R4
    ali_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ali_all[g] >= PT_W'(MIN_ALI));
  end
endmodule

bind sec_binpt_bank sbp_chk #(
  .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .MIN_PRI(MIN_PRI), .MIN_ALI(MIN_ALI), .OFFSET(OFFSET), .CPU_W(CPU_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .secure_i(secure_i), .sec_ext_i(sec_ext_i), .cpu_sel_i(cpu_sel_i),
  .ctl_we_i(ctl_we_i), .ctl_cpu_i(ctl_cpu_i), .ctl_share_i(ctl_share_i),
  .rdata_o(rdata_o), .pri_all(pri_all), .ali_all(ali_all), .share_all(share_all)
);

// File: tb/tb_sec_binpt_bank.sv
`timescale 1ns/1ps
module tb_sec_binpt_bank;
  localparam int NCPU = 4;
  localparam int OFF  = 'h8;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 0, we_i = 0, secure_i = 0, sec_ext_i = 1;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [1:0]  cpu_sel_i = '0, ctl_cpu_i = '0;
  logic        ctl_we_i = 0, ctl_share_i = 0;
  logic [31:0] rdata_o;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_pri[NCPU], m_ali[NCPU], m_shr[NCPU];
  int m_rd = 0;

  always #5 clk_i = ~clk_i;

  sec_binpt_bank dut (.*);

  function automatic int lo_clamp(int d, int lo);
    int v = d & 7;
    return (v < lo) ? lo : v;
  endfunction

  task automatic check(string tag, int exp);
    checks++;
    if (rdata_o !== 32'(exp)) begin
      errors++;
      $display("FAIL %s: rdata actual %0d expected %0d", tag, rdata_o, exp);
    end
  endtask

  // one bus cycle; model updated, then compared one cycle later at negedge
  task automatic cyc(bit rq, bit w, int a, int d, int cpu, bit sec, bit ext,
                     bit cw, int ccpu, bit cv, string tag);
    req_i = rq; we_i = w; addr_i = 12'(a); wdata_i = 32'(d); cpu_sel_i = 2'(cpu);
    secure_i = sec; sec_ext_i = ext; ctl_we_i = cw; ctl_cpu_i = 2'(ccpu); ctl_share_i = cv;
    if (rq && a == OFF) begin
      if (!ext || sec) begin
        if (w) m_pri[cpu] = lo_clamp(d, 2); else m_rd = m_pri[cpu];
      end else if (m_shr[cpu] != 0) begin
        if (!w) m_rd = (m_pri[cpu] >= 7) ? 7 : m_pri[cpu] + 1;
      end else begin
        if (w) m_ali[cpu] = lo_clamp(d, 3); else m_rd = m_ali[cpu];
      end
    end else if (rq && !w) m_rd = 0;
    if (cw) m_shr[ccpu] = cv;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 0; we_i = 0; ctl_we_i = 0;
    check(tag, m_rd);
  endtask

  task automatic rd(int cpu, bit sec, bit ext, string tag);
    cyc(1, 0, OFF, 0, cpu, sec, ext, 0, 0, 0, tag);
  endtask
  task automatic wr(int cpu, bit sec, bit ext, int d, string tag);
    cyc(1, 1, OFF, d, cpu, sec, ext, 0, 0, 0, tag);
  endtask
  task automatic ctl(int cpu, bit v, string tag);
    cyc(0, 0, OFF, 0, 0, 0, 1, 1, cpu, v, tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("TIMEOUT watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCPU; i++) begin m_pri[i] = 2; m_ali[i] = 3; m_shr[i] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check("R1 reset rdata", 0);
    rd(0, 1, 1, "R1 primary reset");
    rd(3, 0, 1, "R1 alias reset");
    // R3 primary writes with clamp and mask
    wr(0, 1, 1, 5, "R3 write");            rd(0, 1, 1, "R3 readback 5");
    wr(0, 1, 1, 0, "R3 write low");        rd(0, 1, 1, "R3 clamp to 2");
    wr(0, 1, 1, 32'hFFFF_FFF9, "R3 mask"); rd(0, 1, 1, "R3 masked clamp");
    wr(0, 0, 0, 4, "R3 no-ext write");     rd(0, 0, 0, "R3 no-ext read");
    rd(0, 1, 1, "R3 secure sees no-ext write");
    // R4 alias
    wr(0, 0, 1, 1, "R4 write low");        rd(0, 0, 1, "R4 clamp to 3");
    wr(0, 0, 1, 6, "R4 write");            rd(0, 0, 1, "R4 readback 6");
    rd(0, 1, 1, "R4 primary untouched");
    // R8 / R5 sharing
    ctl(0, 1, "R8 share on");
    rd(0, 0, 1, "R5 primary+1");
    wr(0, 1, 1, 7, "R5 set 7");            rd(0, 0, 1, "R5 saturate 7");
    wr(0, 1, 1, 2, "R5 set 2");            rd(0, 0, 1, "R5 2 reads 3");
    // R6 dropped writes
    wr(0, 0, 1, 7, "R6 ns write");         rd(0, 1, 1, "R6 primary kept");
    ctl(0, 0, "R8 share off");             rd(0, 0, 1, "R6 alias kept");
    // R8 same-cycle: access uses old bit
    cyc(1, 0, OFF, 0, 0, 0, 1, 1, 0, 1, "R8 old bit in same cycle");
    rd(0, 0, 1, "R8 new bit next cycle");
    ctl(0, 0, "R8 share off again");
    // R7 per-CPU
    wr(1, 1, 1, 6, "R7 cpu1 write");       rd(0, 1, 1, "R7 cpu0 untouched");
    rd(1, 1, 1, "R7 cpu1 value");
    ctl(1, 1, "R8 cpu1 share");            rd(0, 0, 1, "R7 cpu0 share still off");
    rd(1, 0, 1, "R7 cpu1 shared 7");
    // R2 address decode
    cyc(1, 1, 'hC, 7, 0, 1, 1, 0, 0, 0, "R2 off-offset write");
    rd(0, 1, 1, "R2 value unchanged");
    cyc(1, 0, 'hC, 0, 0, 1, 1, 0, 0, 0, "R2 off-offset read 0");
    // R9 hold
    rd(1, 1, 1, "R9 read");
    cyc(0, 0, OFF, 0, 0, 0, 1, 0, 0, 0, "R9 hold idle");
    wr(2, 1, 1, 5, "R9 hold over write");
    // random phase
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom);
      cyc(r[0], r[1], r[2] ? 'hC : OFF, int'($urandom), r[4:3], r[5], r[6] | r[7],
          r[8] & r[9], r[11:10], r[12], "R9 random");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule